// File: doc/BRIEF.md
# Zero-Turnaround Synchronous Static Memory

This block is a synchronous static memory whose command bus can go from a read straight to a write, or back, with no idle cycle in between. Address and control are registered on the rising clock edge. The write data for a command is taken on the same bus slot where a read's data would appear, so each command owns exactly one data-bus slot. The slot falls one edge after the command in flow-through mode and two edges after it in pipelined mode. The default size is 1024 words of 36 bits, organised as four 9-bit byte lanes.

A host starts a single access or a four-beat burst with a load command. It continues the burst by raising the advance input. Three chip-select inputs, a clock enable, per-lane write masks, a burst-order select, an asynchronous output enable and a sleep request complete the interface. The pad driver is split into a data-out bus and a separate enable.

Top module: `nbt_sram`

## Requirements
- R1: After reset, `dOutEn` is low and `dOut` is all zeros until the first read slot.
- R2: While `cenN` is high at a rising edge, no command is accepted, no write is committed and `dOut` does not change.
- R3: A load command (`burstAdv` low) is accepted only when `ce1N` is low, `ce2` is high and `ce3N` is low. Otherwise it is a deselect: nothing is written, `dOutEn` stays low in its slot, and any open burst ends.
- R4: With `modeFlowN` high (pipelined), read data is driven during the cycle after the next edge following the read command. The write data for a command at edge k is captured at edge k+2.
- R5: With `modeFlowN` low (flow-through), read data is driven right after the command edge. The write data for a command at edge k is captured at edge k+1.
- R6: Lane i covers data bits 9i+8 down to 9i and is written only when `bwN[i]` is low. A write with all four `bwN` bits high changes nothing.
- R7: `burstAdv` high continues the open burst with the same direction, using beat index b = previous index + 1 mod 4. The address keeps its upper bits and takes low bits preset+b mod 4 when `burstLinearN` is low, or preset XOR b when it is high. An advance with no open burst does nothing.
- R8: A read issued directly after a write to the same address, with zero idle cycles, returns the newly written lanes merged with the old contents of the unwritten lanes.
- R9: `oeN` high forces `dOutEn` low at once. `dOutEn` is also low in any slot that does not carry read data, which includes write slots.
- R10: While `sleepReq` is high, `dOutEn` is low, and load and advance commands are treated as deselects. Writes already in flight still complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| cenN | input | 1 | Clock enable, active low |
| ce1N | input | 1 | Chip select, active low |
| ce2 | input | 1 | Chip select, active high |
| ce3N | input | 1 | Chip select, active low |
| weN | input | 1 | Write command when low, read when high |
| burstAdv | input | 1 | High: advance burst; low: load new address |
| bwN | input | 4 | Per-lane write enables, active low |
| addr | input | 10 | Word address; bits 1:0 preset the burst |
| dIn | input | 36 | Write data bus |
| modeFlowN | input | 1 | Low: flow-through; high: pipelined |
| burstLinearN | input | 1 | Low: linear burst; high: interleaved |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleepReq | input | 1 | Sleep request, active high |
| dOut | output | 36 | Read data bus |
| dOutEn | output | 1 | Data driver enable |

## Verification
The assertions watch every cycle for the output-enable and sleep overrides on `dOutEn`, for `dOut` holding still through a clock-enable stall, for deselects leaving the bus undriven, and for read commands lighting `dOutEn` in the slot their mode dictates. Whether the right word arrives can only be seen in the bench's scenarios, which compare against a reference memory. These cover burst address order in both orderings, lane masking, a read right behind a write to the same word, and commands ignored under stall, deselect or sleep.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic step;    // clock enable active: pipeline advances this edge
    logic wrEn;    // commit a write at this edge
    logic rdLive;  // stage-1 command is a read
    logic flow;    // flow-through mode selected
  } strobe_t;

  // Low two address bits for a burst beat.
  function automatic logic [1:0] burstLsb(input logic [1:0] preset,
                                          input logic [1:0] beat,
                                          input logic interleave);
    return interleave ? (preset ^ beat) : (preset + beat);
  endfunction

endpackage

// File: rtl/nbt_sram_ctrl.sv
module nbt_sram_ctrl
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cenN,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              weN,
  input  logic              burstAdv,
  input  logic [LANES-1:0]  bwN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              modeFlowN,
  input  logic              burstLinearN,
  input  logic              sleepReq,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  wrLanes,
  output logic [LANES-1:0]  fwdLanes
);

  logic selected, step, flow;
  logic bActive, bWrite;
  logic [ADDR_W-1:0] bBase;
  logic [1:0] bIdx, nxtIdx;
  logic newValid, newWr;
  logic [ADDR_W-1:0] newAddr;

  logic s1Valid, s1Wr, s2Valid, s2Wr;
  logic [ADDR_W-1:0] s1Addr, s2Addr;
  logic [LANES-1:0] s1Bw, s2Bw;

  assign selected = !ce1N && ce2 && !ce3N && !sleepReq;
  assign step     = !cenN;
  assign flow     = !modeFlowN;
  assign nxtIdx   = bIdx + 2'd1;

  // Command decode: load or burst advance.
  always_comb begin
    if (!burstAdv) begin
      newValid = selected;
      newWr    = !weN;
      newAddr  = addr;
    end else begin
      newValid = bActive && !sleepReq;
      newWr    = bWrite;
      newAddr  = {bBase[ADDR_W-1:2], burstLsb(bBase[1:0], nxtIdx, burstLinearN)};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bActive <= 1'b0;
      bWrite  <= 1'b0;
      bBase   <= '0;
      bIdx    <= '0;
      s1Valid <= 1'b0;
      s1Wr    <= 1'b0;
      s1Addr  <= '0;
      s1Bw    <= '1;
      s2Valid <= 1'b0;
      s2Wr    <= 1'b0;
      s2Addr  <= '0;
      s2Bw    <= '1;
    end else if (step) begin
      if (!burstAdv) begin
        bActive <= selected;
        bWrite  <= !weN;
        bBase   <= addr;
        bIdx    <= '0;
      end else if (newValid) begin
        bIdx    <= nxtIdx;
      end
      s1Valid <= newValid;
      s1Wr    <= newWr;
      s1Addr  <= newAddr;
      s1Bw    <= bwN;
      s2Valid <= s1Valid;
      s2Wr    <= s1Wr;
      s2Addr  <= s1Addr;
      s2Bw    <= s1Bw;
    end
  end

  // Late write: stage 1 in flow-through, stage 2 in pipelined mode.
  assign strb.step   = step;
  assign strb.flow   = flow;
  assign strb.rdLive = s1Valid && !s1Wr;
  assign strb.wrEn   = step && (flow ? (s1Valid && s1Wr) : (s2Valid && s2Wr));
  assign wrAddr      = flow ? s1Addr : s2Addr;
  assign wrLanes     = ~(flow ? s1Bw : s2Bw);
  assign rdAddr      = s1Addr;

  // Pipelined read meets a write whose data lands on the same edge.
  assign fwdLanes = (!flow && s2Valid && s2Wr && (s2Addr == s1Addr)) ? ~s2Bw : '0;

endmodule

// File: rtl/nbt_sram_dp.sv
module nbt_sram_dp
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  strobe_t                 strb,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        wrLanes,
  input  logic [LANES-1:0]        fwdLanes,
  input  logic [LANES*LANE_W-1:0] dIn,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    readOn
);

  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdWord, merged, outReg;
  logic outValid;

  always_ff @(posedge clk) begin
    if (strb.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrLanes[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= dIn[l*LANE_W +: LANE_W];
      end
    end
  end

  assign rdWord = mem[rdAddr];

  for (genvar g = 0; g < LANES; g++) begin : gMerge
    assign merged[g*LANE_W +: LANE_W] = fwdLanes[g] ? dIn[g*LANE_W +: LANE_W]
                                                    : rdWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outReg   <= '0;
      outValid <= 1'b0;
    end else if (strb.step) begin
      outValid <= strb.rdLive;
      if (strb.rdLive) outReg <= merged;
    end
  end

  assign dOut   = strb.flow ? (strb.rdLive ? rdWord : '0) : outReg;
  assign readOn = strb.flow ? strb.rdLive : outValid;

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cenN,
  input  logic                    ce1N,
  input  logic                    ce2,
  input  logic                    ce3N,
  input  logic                    weN,
  input  logic                    burstAdv,
  input  logic [LANES-1:0]        bwN,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] dIn,
  input  logic                    modeFlowN,
  input  logic                    burstLinearN,
  input  logic                    oeN,
  input  logic                    sleepReq,
  output logic [LANES*LANE_W-1:0] dOut,
  output logic                    dOutEn
);

  strobe_t strb;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic [LANES-1:0] wrLanes, fwdLanes;
  logic readOn;

  nbt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .weN(weN), .burstAdv(burstAdv), .bwN(bwN), .addr(addr), .modeFlowN(modeFlowN),
    .burstLinearN(burstLinearN), .sleepReq(sleepReq), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrLanes(wrLanes), .fwdLanes(fwdLanes)
  );

  nbt_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrLanes(wrLanes), .fwdLanes(fwdLanes), .dIn(dIn), .dOut(dOut), .readOn(readOn)
  );

  // Asynchronous overrides on the driver enable.
  assign dOutEn = readOn && !oeN && !sleepReq;

endmodule

// File: rtl/nbt_sram_chk.sv
module nbt_sram_chk #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cenN,
  input logic                    ce1N,
  input logic                    ce2,
  input logic                    ce3N,
  input logic                    weN,
  input logic                    burstAdv,
  input logic                    modeFlowN,
  input logic                    oeN,
  input logic                    sleepReq,
  input logic [LANES*LANE_W-1:0] dOut,
  input logic                    dOutEn
);

  logic sel, rdCmd;
  assign sel   = !ce1N && ce2 && !ce3N;
  assign rdCmd = !cenN && !burstAdv && sel && weN && !sleepReq;

  assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cenN |=> $stable(dOut));

  assert_desel_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cenN && !burstAdv && !sel && !modeFlowN) |=> (!dOutEn || modeFlowN));

  assert_pipe_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rdCmd && modeFlowN) ##1 (!cenN && modeFlowN) |=> (dOutEn || oeN || sleepReq));

  assert_flow_lat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdCmd && !modeFlowN) |=> (dOutEn || oeN || sleepReq || modeFlowN));

  assert_oe_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    oeN |-> !dOutEn);

  assert_sleep_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sleepReq |-> !dOutEn);

endmodule

bind nbt_sram nbt_sram_chk #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
  .weN(weN), .burstAdv(burstAdv), .modeFlowN(modeFlowN), .oeN(oeN),
  .sleepReq(sleepReq), .dOut(dOut), .dOutEn(dOutEn)
);

// File: tb/nbt_sram_tb_top.sv
module nbt_sram_tb_top;
  localparam int AW = 10;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int DW = NL * LW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cenN = 1'b0, ce1N = 1'b1, ce2 = 1'b0, ce3N = 1'b1, weN = 1'b1, burstAdv = 1'b0;
  logic [NL-1:0] bwN = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dIn = '0;
  logic modeFlowN = 1'b1, burstLinearN = 1'b0, oeN = 1'b0, sleepReq = 1'b0;
  logic [DW-1:0] dOut;
  logic dOutEn;

  always #5 clk = ~clk;

  nbt_sram dut_i (
    .clk(clk), .rst_n(rst_n), .cenN(cenN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .weN(weN), .burstAdv(burstAdv), .bwN(bwN), .addr(addr), .dIn(dIn),
    .modeFlowN(modeFlowN), .burstLinearN(burstLinearN), .oeN(oeN),
    .sleepReq(sleepReq), .dOut(dOut), .dOutEn(dOutEn)
  );

  int checks = 0, fails = 0;
  string tag = "R1";
  bit finished = 1'b0;

  typedef struct { bit v; bit wr; int a; logic [NL-1:0] bw; } bcmd_t;
  bcmd_t curBus, nextBus;
  bit mAct, mWr;
  int mBase, mIdx;
  logic [DW-1:0] refMem [0:(1<<AW)-1];

  function automatic int burstAddr(int base, int idx, bit inter);
    int p = base & 3;
    int lsb = inter ? (p ^ idx) : ((p + idx) & 3);
    return (base & ~3) | lsb;
  endfunction

  task automatic check(bit ok, string t, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  // Reference model of one accepted edge, built from the requirements.
  task automatic modelEdge();
    bcmd_t nc, prev;
    if (cenN) return;
    if (curBus.v && curBus.wr)
      for (int l = 0; l < NL; l++)
        if (!curBus.bw[l]) refMem[curBus.a][l*LW +: LW] = dIn[l*LW +: LW];
    nc = '{0, 0, 0, '1};
    if (!burstAdv) begin
      bit s = !ce1N && ce2 && !ce3N && !sleepReq;
      mAct = s; mWr = !weN; mBase = int'(addr); mIdx = 0;
      nc = '{s, !weN, int'(addr), bwN};
    end else if (mAct && !sleepReq) begin
      mIdx = (mIdx + 1) & 3;
      nc = '{1, mWr, burstAddr(mBase, mIdx, burstLinearN), bwN};
    end
    prev = nextBus;
    nextBus = nc;
    curBus = modeFlowN ? prev : nc;
  endtask

  task automatic cyc();
    bit e;
    @(posedge clk);
    if (rst_n) modelEdge();
    @(negedge clk);
    e = curBus.v && !curBus.wr && !oeN && !sleepReq;
    check(dOutEn === e, {tag, " enable"}, DW'(dOutEn), DW'(e));
    if (e) check(dOut === refMem[curBus.a], {tag, " data"}, dOut, refMem[curBus.a]);
    dIn = DW'({$urandom(), $urandom()});
  endtask

  task automatic sel3(bit a, bit b, bit c);
    ce1N = a; ce2 = b; ce3N = c;
  endtask

  task automatic rdOp(int a);
    cenN = 0; burstAdv = 0; sel3(0, 1, 0); weN = 1; addr = AW'(a); cyc();
  endtask

  task automatic wrOp(int a, logic [NL-1:0] bw);
    cenN = 0; burstAdv = 0; sel3(0, 1, 0); weN = 0; bwN = bw; addr = AW'(a); cyc();
  endtask

  task automatic advOp(logic [NL-1:0] bw);
    cenN = 0; burstAdv = 1; bwN = bw; cyc();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      cenN = 0; burstAdv = 0; sel3(1, 0, 1); weN = 1; cyc();
    end
  endtask

  task automatic stall(int n);
    for (int i = 0; i < n; i++) begin
      cenN = 1; burstAdv = 0; weN = 0; addr = AW'(i); cyc();
    end
    cenN = 0;
  endtask

  task automatic randomPhase(int n);
    for (int i = 0; i < n; i++) begin
      int r = $urandom % 100;
      oeN = ($urandom % 10) == 0;
      sleepReq = ($urandom % 20) == 0;
      if (r < 35) rdOp($urandom % 16);
      else if (r < 60) wrOp($urandom % 16, NL'($urandom));
      else if (r < 85) advOp(NL'($urandom));
      else if (r < 92) stall(1);
      else idle(1);
    end
    oeN = 0; sleepReq = 0;
    idle(3);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    curBus = '{0, 0, 0, '1}; nextBus = curBus; mAct = 0; mWr = 0; mBase = 0; mIdx = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    check(dOutEn === 1'b0, "R1 enable at reset", DW'(dOutEn), '0);
    check(dOut === '0, "R1 data at reset", dOut, '0);
    rst_n = 1;
    idle(2);

    // Fill words 0..15 with linear write bursts, flow-through mode.
    tag = "R5"; modeFlowN = 0; idle(2);
    for (int b = 0; b < 4; b++) begin
      wrOp(b * 4, '0); advOp('0); advOp('0); advOp('0);
    end
    for (int a = 0; a < 16; a++) rdOp(a);

    tag = "R8"; wrOp(5, '0); rdOp(5); wrOp(6, 4'b1010); rdOp(6);
    tag = "R6"; wrOp(7, 4'b1111); rdOp(7); wrOp(8, 4'b0110); rdOp(8);
    tag = "R7"; burstLinearN = 0; rdOp(9); advOp('1); advOp('1); advOp('1);
    burstLinearN = 1; rdOp(9); advOp('1); advOp('1); advOp('1);
    wrOp(13, '0); advOp('0); advOp('0); advOp('0); rdOp(13); advOp('1); advOp('1); advOp('1);
    burstLinearN = 0; idle(1); advOp('1); rdOp(12);
    tag = "R2"; rdOp(3); stall(3); rdOp(0); rdOp(1);
    tag = "R3"; cenN = 0; burstAdv = 0; weN = 0; bwN = '0; addr = 2;
    sel3(1, 1, 0); cyc(); sel3(0, 0, 0); cyc(); sel3(0, 1, 1); cyc();
    rdOp(2);
    tag = "R9"; oeN = 1; rdOp(4); rdOp(4); oeN = 0; rdOp(4); wrOp(4, '0); rdOp(4);
    tag = "R10"; wrOp(10, '0); sleepReq = 1; rdOp(10); wrOp(11, '0); advOp('0);
    sleepReq = 0; rdOp(11); rdOp(10);
    tag = "R5"; randomPhase(300);

    // Pipelined mode.
    tag = "R4"; modeFlowN = 1; idle(3);
    for (int a = 0; a < 16; a++) rdOp(a);
    tag = "R8"; wrOp(5, '0); rdOp(5); wrOp(6, 4'b0101); rdOp(6); rdOp(6);
    wrOp(7, '0); rdOp(8); rdOp(7);
    tag = "R7"; burstLinearN = 1; wrOp(1, '0); advOp('0); advOp('0); advOp('0);
    rdOp(1); advOp('1); advOp('1); advOp('1); burstLinearN = 0;
    tag = "R2"; rdOp(3); stall(2); rdOp(9); stall(1); rdOp(2);
    tag = "R10"; wrOp(14, '0); sleepReq = 1; rdOp(14); wrOp(14, '0);
    sleepReq = 0; rdOp(14); idle(2);
    tag = "R4"; randomPhase(300);

    finished = 1;
    summary();
    $finish;
  end

endmodule